// File: doc/BRIEF.md
# Banked Pin Controller with Event Detection

This block manages one bank of general-purpose pins through a word-addressed register port. Every pin owns a configuration word that chooses its pull setting, direction, output stage type, function select, output inversion and output source. The same word also enables or powers down the input path and selects an event-detection mode. Four shared words serve the whole bank: a live input snapshot, a bank-wide output value word, a one-time lock word and an event status word. Writing 1 to a status bit clears it.

Each input is resynchronised through a flop chain before it is read or compared. Detection covers two level modes and three edge modes. Level modes report the live condition. Edge modes latch their event until software clears it. Once a pin's lock bit is set, its configuration word can no longer change until reset. The pull and function fields are passed out as selects to the pad ring and to the peripheral multiplexer, which lie outside this block.

Top module: `pinbank_ctrl`

Word map, for NUM_PINS pins: words 0..NUM_PINS-1 are the pin configuration words. Word NUM_PINS is the input snapshot and is read-only. NUM_PINS+1 is the output value word. NUM_PINS+2 is the lock word. NUM_PINS+3 is the event status word, with write-1-to-clear bits. Pin n always maps to bit n of a shared word.

## Requirements
- R1: After reset, every pin word reads 0x00008040, and the output value, lock and status words read 0. pad_oe, pad_out, pin_irq, pad_pull and pad_func are all 0.
- R2: A pin word stores only write bits [16:0]. On a read, bit 24 is the pin's qualified input, bits 23:17 and 31:25 are 0, and writes to bit 24 have no effect. Writes to the input snapshot word are ignored.
- R3: Output source is bit 10 of the pin word. At 0 the driven value is the word's bit 16. At 1 it is bit n of the output value word. pad_out follows one clock after a configuration change.
- R4: Bit 11 inverts the driven value. Bit 9 set makes the pin an output (pad_oe = 1). If bit 8 is also set (open drain), pad_oe is 1 only while the inverted value is 0.
- R5: Bits [1:0] appear on the pin's pad_pull field (0 none, 1 up, 2 down, 3 keeper). Bits [14:12] appear on the pin's pad_func field.
- R6: The input passes through SYNC_STAGES flops. Bit n of the snapshot word and bit 24 of pin n's word follow it. While bit 15 is set, the qualified input is 0.
- R7: Detect mode, bits [7:4]: 0xD rising, 0xE falling and 0xF both edges set a sticky status bit. Writing 1 to that bit of the status word clears it. Writing 0 leaves it set.
- R8: Mode 0x0 holds status high while the qualified input is 0. Mode 0x1 holds it high while the input is 1. Writing 1 to clear it has no lasting effect while the level remains.
- R9: Mode 0x4, and every code other than 0x0, 0x1, 0xD, 0xE and 0xF, keeps the pin's status at 0.
- R10: Lock bits can only be set: a write ORs into the lock word. Once a pin's lock bit is 1, writes to that pin's word are ignored, while unlocked pins stay writable.
- R11: Reads have one cycle of latency: bus_rdata is loaded on the clock edge where bus_rd is 1. pin_irq[n] mirrors status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Driven output level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pad_pull | output | 2*NUM_PINS | Pull select, two bits per pin |
| pad_func | output | 3*NUM_PINS | Function select, three bits per pin |
| pin_irq | output | NUM_PINS | Event status per pin |

## Verification
The bench builds the block with NUM_PINS = 8 and SYNC_STAGES = 2, which gives a 4-bit word index. At that size every pin can be put through all 64 combinations of drive controls and all 16 detect-mode codes, so each unlisted code is covered, not just a sample. The small bank also lets the bench walk lock, field-mask and input-gating patterns over every pin, and compute each expected word from the requirement arithmetic.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int CFG_W      = 17;
  localparam int F_PULL     = 0;
  localparam int F_MODE     = 4;
  localparam int F_OD       = 8;
  localparam int F_DIR      = 9;
  localparam int F_SRC      = 10;
  localparam int F_INV      = 11;
  localparam int F_FUNC     = 12;
  localparam int F_INOFF    = 15;
  localparam int F_VAL      = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 17'h08040;

  localparam logic [3:0] DET_LOW  = 4'h0;
  localparam logic [3:0] DET_HIGH = 4'h1;
  localparam logic [3:0] DET_RISE = 4'hD;
  localparam logic [3:0] DET_FALL = 4'hE;
  localparam logic [3:0] DET_BOTH = 4'hF;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect
  import pinbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode,
  input  logic       level,
  input  logic       clr,
  output logic       stat,
  output logic       is_edge,
  output logic       is_off
);
  logic prev;
  logic rise, fall, nxt;

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  always_comb begin
    is_edge = 1'b0;
    is_off  = 1'b0;
    case (mode)
      DET_LOW:  nxt = ~level;
      DET_HIGH: nxt = level;
      DET_RISE: begin nxt = rise | (stat & ~clr);          is_edge = 1'b1; end
      DET_FALL: begin nxt = fall | (stat & ~clr);          is_edge = 1'b1; end
      DET_BOTH: begin nxt = rise | fall | (stat & ~clr);   is_edge = 1'b1; end
      default:  begin nxt = 1'b0;                          is_off  = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      stat <= 1'b0;
    end else begin
      prev <= level;
      stat <= nxt;
    end
  end
endmodule

// File: rtl/pinbank_slice.sv
module pinbank_slice
  import pinbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             clr,
  input  logic             par_bit,
  input  logic             pad_i,
  output logic [31:0]      rd_word,
  output logic             in_val,
  output logic             irq,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic [1:0]       pull,
  output logic [2:0]       func,
  output logic [CFG_W-1:0] cfg_o,
  output logic             is_edge,
  output logic             is_off
);
  logic [CFG_W-1:0] cfg;
  logic             synced;
  logic             drv, lvl;

  always_ff @(posedge clk) begin
    if (rst)        cfg <= CFG_RESET;
    else if (wr_en) cfg <= wdata;
  end

  pinbank_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_i), .q(synced)
  );

  assign in_val = synced & ~cfg[F_INOFF];

  pinbank_detect u_det (
    .clk(clk), .rst(rst), .mode(cfg[F_MODE +: 4]), .level(in_val),
    .clr(clr), .stat(irq), .is_edge(is_edge), .is_off(is_off)
  );

  // output source select then polarity
  assign drv = cfg[F_SRC] ? par_bit : cfg[F_VAL];
  assign lvl = drv ^ cfg[F_INV];

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o    <= 1'b0;
      pad_oe_o <= 1'b0;
    end else begin
      pad_o    <= lvl;
      pad_oe_o <= cfg[F_DIR] & (~cfg[F_OD] | ~lvl);
    end
  end

  assign rd_word = {7'd0, in_val, 7'd0, cfg};
  assign pull    = cfg[F_PULL +: 2];
  assign func    = cfg[F_FUNC +: 3];
  assign cfg_o   = cfg;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_PINS + 4)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [2*NUM_PINS-1:0] pad_pull,
  output logic [3*NUM_PINS-1:0] pad_func,
  output logic [NUM_PINS-1:0]   pin_irq
);
  localparam logic [ADDR_W-1:0] A_SNAP = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] A_OUTV = ADDR_W'(NUM_PINS + 1);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(NUM_PINS + 2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_PINS + 3);

  logic [NUM_PINS-1:0]       par_q, lock_q, in_vec, clr_vec, edge_vec, off_vec;
  logic [31:0]               rd_word [NUM_PINS];
  logic [CFG_W*NUM_PINS-1:0] cfg_flat;
  logic [31:0]               rd_next;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      logic wr_pin;
      assign wr_pin      = bus_wr && (bus_addr == ADDR_W'(gi)) && !lock_q[gi];
      assign clr_vec[gi] = bus_wr && (bus_addr == A_STAT) && bus_wdata[gi];

      pinbank_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
        .clk(clk), .rst(rst), .wr_en(wr_pin), .wdata(bus_wdata[CFG_W-1:0]),
        .clr(clr_vec[gi]), .par_bit(par_q[gi]), .pad_i(pad_in[gi]),
        .rd_word(rd_word[gi]), .in_val(in_vec[gi]), .irq(pin_irq[gi]),
        .pad_o(pad_out[gi]), .pad_oe_o(pad_oe[gi]),
        .pull(pad_pull[2*gi +: 2]), .func(pad_func[3*gi +: 3]),
        .cfg_o(cfg_flat[CFG_W*gi +: CFG_W]),
        .is_edge(edge_vec[gi]), .is_off(off_vec[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= '0;
      lock_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_OUTV) par_q  <= bus_wdata[NUM_PINS-1:0];
      if (bus_addr == A_LOCK) lock_q <= lock_q | bus_wdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (bus_addr == ADDR_W'(i)) rd_next = rd_word[i];
    if (bus_addr == A_SNAP) rd_next = 32'(in_vec);
    if (bus_addr == A_OUTV) rd_next = 32'(par_q);
    if (bus_addr == A_LOCK) rd_next = 32'(lock_q);
    if (bus_addr == A_STAT) rd_next = 32'(pin_irq);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_rd,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_rdata,
  input logic [NUM_PINS-1:0]    pad_out,
  input logic [NUM_PINS-1:0]    pad_oe,
  input logic [NUM_PINS-1:0]    pin_irq,
  input logic [NUM_PINS-1:0]    lock_q,
  input logic [NUM_PINS-1:0]    clr_vec,
  input logic [NUM_PINS-1:0]    edge_vec,
  input logic [NUM_PINS-1:0]    off_vec,
  input logic [17*NUM_PINS-1:0] cfg_flat
);
  p_oe_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0))
    else $error("R1 pad_oe not idle after reset");

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr < ADDR_W'(NUM_PINS)) |=>
      (bus_rdata[23:17] == 7'd0 && bus_rdata[31:25] == 7'd0))
    else $error("R2 reserved bits nonzero");

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_chk
      p_od_nodrive_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_flat[17*gi + 8] |=> (!pad_oe[gi] || !pad_out[gi]))
        else $error("R4 open drain drives high");

      p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (edge_vec[gi] && pin_irq[gi] && !clr_vec[gi]) |=> pin_irq[gi])
        else $error("R7 sticky status dropped");

      p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        off_vec[gi] |=> !pin_irq[gi])
        else $error("R9 disabled pin raised status");

      p_lock_keep_r10: assert property (@(posedge clk) disable iff (rst)
        lock_q[gi] |=> lock_q[gi])
        else $error("R10 lock bit cleared");

      p_lock_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        lock_q[gi] |=> $stable(cfg_flat[17*gi +: 17]))
        else $error("R10 locked word changed");
    end
  endgenerate
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pin_irq(pin_irq), .lock_q(lock_q), .clr_vec(clr_vec),
  .edge_vec(edge_vec), .off_vec(off_vec), .cfg_flat(cfg_flat)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_SNAP = AW'(N);
  localparam logic [AW-1:0] A_OUTV = AW'(N + 1);
  localparam logic [AW-1:0] A_LOCK = AW'(N + 2);
  localparam logic [AW-1:0] A_STAT = AW'(N + 3);
  localparam logic [31:0] MASK = 32'h0001FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pin_irq;
  logic [2*N-1:0] pad_pull;
  logic [3*N-1:0] pad_func;

  int checks = 0;
  int errors = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  pinbank_ctrl #(.NUM_PINS(N), .SYNC_STAGES(2), .ADDR_W(AW)) u_pinbank_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_func(pad_func), .pin_irq(pin_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(1);

    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 0);
    check("R1 pad_out", 32'(pad_out), 0);
    check("R1 pin_irq", 32'(pin_irq), 0);
    check("R1 pad_pull", 32'(pad_pull), 0);
    check("R1 pad_func", 32'(pad_func), 0);
    for (int i = 0; i < N; i++) begin
      rd(AW'(i), d); check("R1 pin word", d, 32'h8040);
    end
    rd(A_OUTV, d); check("R1 outv", d, 0);
    rd(A_LOCK, d); check("R1 lock", d, 0);
    rd(A_STAT, d); check("R1 stat", d, 0);

    // R2 field mask, R11 read latency
    for (int i = 0; i < N; i++) begin
      logic [31:0] p;
      wr(AW'(i), 32'hFFFFFFFF);
      rd(AW'(i), d); check("R2 all ones", d, MASK);
      p = (32'(i) * 32'h1F2E3D4C) ^ 32'h5A5A5A5A;
      p[15] = 1'b1;
      wr(AW'(i), p);
      rd(AW'(i), d); check("R2 pattern R11", d, p & MASK);
      wr(AW'(i), 32'h8040);
    end

    // R5 pull and function selects
    for (int i = 0; i < N; i++) begin
      logic [1:0] pl; logic [2:0] fn;
      pl = 2'(i + 1); fn = 3'(7 - i);
      wr(AW'(i), 32'h8040 | 32'(pl) | (32'(fn) << 12));
      settle(1);
      check("R5 pull", 32'(pad_pull[2*i +: 2]), 32'(pl));
      check("R5 func", 32'(pad_func[3*i +: 3]), 32'(fn));
      wr(AW'(i), 32'h8040);
    end

    // R3 and R4 drive sweep
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 64; c++) begin
        logic od, dir, src, inv, val, par, drv, lv, oe;
        od = c[0]; dir = c[1]; src = c[2]; inv = c[3]; val = c[4]; par = c[5];
        wr(A_OUTV, par ? (32'd1 << i) : 32'd0);
        wr(AW'(i), 32'h8040 | (32'(od) << 8) | (32'(dir) << 9) | (32'(src) << 10)
                   | (32'(inv) << 11) | (32'(val) << 16));
        settle(2);
        drv = src ? par : val;
        lv  = drv ^ inv;
        oe  = dir & (~od | ~lv);
        check("R3 pad_out", 32'(pad_out[i]), 32'(lv));
        check("R4 pad_oe", 32'(pad_oe[i]), 32'(oe));
      end
      wr(AW'(i), 32'h8040);
    end
    wr(A_OUTV, 0);

    // R6 input path
    for (int i = 0; i < N; i++) wr(AW'(i), 32'h0040);
    foreach (pad_in[k]) pad_in[k] = 1'b0;
    for (int t = 0; t < 5; t++) begin
      logic [N-1:0] pat;
      pat = N'(32'hA5 ^ (t * 32'h37));
      @(negedge clk) pad_in = pat;
      settle(4);
      rd(A_SNAP, d); check("R6 snapshot", d, 32'(pat));
      rd(AW'(t), d); check("R6 bit24", d, 32'h0040 | (32'(pat[t]) << 24));
    end
    wr(A_SNAP, 32'hFF);
    @(negedge clk) pad_in = '1;
    wr(AW'(2), 32'h8040);
    settle(4);
    rd(A_SNAP, d); check("R6 pad off R2 snapshot ro", d, 32'hFB);
    rd(AW'(2), d); check("R6 pad off bit24", d, 32'h8040);
    @(negedge clk) pad_in = '0;
    for (int i = 0; i < N; i++) wr(AW'(i), 32'h8040);
    settle(4);

    // R7 R8 R9 mode sweep
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 16; m++) begin
        logic e_hi, e_lo;
        e_hi = (m == 1) || (m == 13) || (m == 15);
        e_lo = (m == 0) || (m == 13) || (m == 14) || (m == 15);
        wr(AW'(i), 32'(m) << 4);
        settle(4);
        wr(A_STAT, 32'd1 << i);
        settle(2);
        @(negedge clk) pad_in[i] = 1'b1;
        settle(4);
        rd(A_STAT, d); check("R7 R8 R9 after rise", 32'(d[i]), 32'(e_hi));
        check("R11 pin_irq", 32'(pin_irq[i]), 32'(e_hi));
        @(negedge clk) pad_in[i] = 1'b0;
        settle(4);
        rd(A_STAT, d); check("R7 R8 R9 after fall", 32'(d[i]), 32'(e_lo));
        wr(AW'(i), 32'h8040);
        settle(2);
      end
    end

    // R7 clear semantics on pin 3
    wr(AW'(3), 32'h00D0);
    settle(3);
    @(negedge clk) pad_in[3] = 1'b1;
    settle(4);
    @(negedge clk) pad_in[3] = 1'b0;
    settle(4);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R7 zero write keeps", d, 32'h08);
    wr(A_STAT, 32'h08);
    settle(1);
    rd(A_STAT, d); check("R7 w1c clears", d, 32'h0);
    // R8 level cannot be cleared while present
    wr(AW'(3), 32'h0010);
    @(negedge clk) pad_in[3] = 1'b1;
    settle(4);
    wr(A_STAT, 32'h08);
    settle(1);
    rd(A_STAT, d); check("R8 level persists", d, 32'h08);
    @(negedge clk) pad_in[3] = 1'b0;
    settle(4);
    rd(A_STAT, d); check("R8 level drops", d, 32'h0);
    wr(AW'(3), 32'h8040);

    // R10 lock
    wr(A_LOCK, 32'h05);
    rd(A_LOCK, d); check("R10 lock set", d, 32'h05);
    wr(A_LOCK, 32'h0A);
    rd(A_LOCK, d); check("R10 lock or", d, 32'h0F);
    wr(A_LOCK, 32'h00);
    rd(A_LOCK, d); check("R10 lock sticky", d, 32'h0F);
    wr(AW'(0), 32'h00000241);
    rd(AW'(0), d); check("R10 locked word", d, 32'h8040);
    settle(1);
    check("R10 locked no drive", 32'(pad_oe[0]), 0);
    wr(AW'(5), 32'h00008042);
    rd(AW'(5), d); check("R10 unlocked word", d, 32'h8042);

    finish_run();
  end
endmodule